// File: doc/BRIEF.md
# Switching-Regulator PWM Controller

This block is the digital pulse-width-modulation engine for an external DC-DC converter switch. It counts a programmable switching period and drives a primary gate output high for the first part of each period. It also produces a secondary gate output that is always the logical inverse of the primary. Every period closes with a forced off interval. Its length is set by a register and equals the field value plus four clocks, so the magnetic element can discharge into the output capacitor.

The on time is regulated in closed loop. A one-bit comparator input says whether the sensed output voltage sits below its target. At every period boundary the stored pulse width moves one clock up or down. It saturates at zero and at the longest width the off interval permits. An overload input turns the switch off in the same cycle. The pulse then stays blanked until the period ends, and the next period resumes with the stored width unchanged. A calibration request through the register bus opens a 64-clock busy window. Switching is suppressed for that window.

The register bus is a plain synchronous write port with a combinational read. It has no handshake and no back-pressure: a write takes effect at the clock edge where `reg_wr` is high, and `reg_rdata` follows `reg_addr` in the same cycle. The comparator and overload pins are level signals, not streams.

Top module: `swreg_pwm_ctrl`

## Requirements
- R1: Address 0 bit 0 is the converter-off bit, 1 after reset. While it is 1, `gate_p` is 0 and the counter and blanking are cleared. Writing 0 starts switching.
- R2: `gate_n` is always the inverse of `gate_p`, including in reset, while off and during calibration.
- R3: Address 1 holds the period P in clocks (reset 40). Each period `gate_p` is high for the first W clocks, where W is the applied pulse width.
- R4: Address 2 bits 4:0 hold the off field T. W never exceeds P_eff − (T+4), so `gate_p` is low for at least T+4 clocks of every period.
- R5: At each period boundary W rises by one if `fb_below` is 1 and falls by one if it is 0. W saturates at 0 and at the R4 maximum. W resets to 0 and holds while switching is stopped.
- R6: While `ovl_in` is 1, `gate_p` is 0 in that same cycle, with no clock delay.
- R7: An overload sampled at any edge except a boundary edge blanks `gate_p` until the next boundary. At the boundary edge the blank is cleared, so an overload present only in the last cycle of a period does not affect the next period. The stored W is not altered by overload.
- R8: A period value below T+5 is used as T+5.
- R9: Address 3 reads the applied W. Writes to address 3 have no effect.
- R10: Writing address 2 with bit 7 set starts a 64-clock calibration. Address 2 bit 7 reads 1 for its duration and then clears by itself. T is written by the same write. `gate_p` is 0 and the counter restarts while calibration runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (16.384 MHz in the target system) |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| fb_below | input | 1 | Comparator: 1 when the output is below its reference |
| ovl_in | input | 1 | Overload detect, active high |
| gate_p | output | 1 | Primary switch drive, active high |
| gate_n | output | 1 | Secondary drive, inverse polarity |

## Verification
Overload blanking and the period boundary can both act on the same clock edge. The boundary edge clears the blank while an overload sampled on that edge would set it. To provoke this, the bench first lets the width settle at its maximum. It then aligns to the falling edge of a pulse and counts forward to the last cycle of the period. It raises `ovl_in` for exactly that cycle. The check passes if `gate_p` is high as soon as the overload drops in the first cycle of the new period, and stays high for the following clocks.

// File: rtl/swreg_pkg.sv
package swreg_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int TOF_ADD = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL = 2'd0,
    RA_PER  = 2'd1,
    RA_TOFF = 2'd2,
    RA_WID  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/swreg_regs.sv
module swreg_regs
  import swreg_pkg::*;
#(
  parameter int PER_W   = 8,
  parameter int TOF_W   = 5,
  parameter int CAL_CYC = 64,
  parameter int PER_RST = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PER_W-1:0]  width_rd,
  output logic [DATA_W-1:0] rdata,
  output logic              conv_off,
  output logic [PER_W-1:0]  period,
  output logic [TOF_W-1:0]  toff,
  output logic              cal_busy
);
  localparam int CW = $clog2(CAL_CYC + 1);

  logic [CW-1:0] cal_cnt;
  logic          cal_go;
  logic          unused_wbits;

  assign unused_wbits = ^wdata;
  assign cal_go   = wr && (addr == RA_TOFF) && wdata[DATA_W-1] && !cal_busy;
  assign cal_busy = (cal_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_off <= 1'b1;
      period   <= PER_W'(PER_RST);
      toff     <= '0;
    end else if (wr) begin
      case (addr)
        RA_CTRL: conv_off <= wdata[0];
        RA_PER:  period   <= wdata[PER_W-1:0];
        RA_TOFF: toff     <= wdata[TOF_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cal_cnt <= '0;
    else if (cal_go)  cal_cnt <= CW'(CAL_CYC);
    else if (cal_busy) cal_cnt <= cal_cnt - 1'b1;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_CTRL: rdata[0] = conv_off;
      RA_PER:  rdata[PER_W-1:0] = period;
      RA_TOFF: begin
        rdata[TOF_W-1:0]  = toff;
        rdata[DATA_W-1]   = cal_busy;
      end
      default: rdata[PER_W-1:0] = width_rd;
    endcase
  end
endmodule

// File: rtl/swreg_loop.sv
module swreg_loop #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             bnd,
  input  logic             fb_below,
  input  logic [PER_W-1:0] w_max,
  output logic [PER_W-1:0] w_use
);
  logic [PER_W-1:0] width_q;

  assign w_use = (width_q > w_max) ? w_max : width_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= '0;
    end else if (run && bnd) begin
      if (fb_below) width_q <= (w_use < w_max) ? w_use + 1'b1 : w_max;
      else          width_q <= (w_use != '0) ? w_use - 1'b1 : '0;
    end
  end
endmodule

// File: rtl/swreg_pwm.sv
module swreg_pwm #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PER_W-1:0] p_eff,
  input  logic [PER_W-1:0] w_use,
  input  logic             ovl_in,
  output logic             bnd,
  output logic             blank_q,
  output logic             gate_p
);
  logic [PER_W-1:0] cnt;

  assign bnd    = run && (cnt >= p_eff - 1'b1);
  assign gate_p = run && (cnt < w_use) && !blank_q && !ovl_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      blank_q <= 1'b0;
    end else if (!run) begin
      cnt     <= '0;
      blank_q <= 1'b0;
    end else if (bnd) begin
      cnt     <= '0;
      blank_q <= 1'b0;
    end else begin
      cnt     <= cnt + 1'b1;
      blank_q <= blank_q | ovl_in;
    end
  end
endmodule

// File: rtl/swreg_pwm_ctrl.sv
module swreg_pwm_ctrl
  import swreg_pkg::*;
#(
  parameter int PER_W   = 8,
  parameter int TOF_W   = 5,
  parameter int CAL_CYC = 64,
  parameter int PER_RST = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        fb_below,
  input  logic        ovl_in,
  output logic        gate_p,
  output logic        gate_n
);
  logic             conv_off, cal_busy, run, bnd, blank_q;
  logic [PER_W-1:0] period, p_eff, w_max, w_use, min_per, off_len;
  logic [TOF_W-1:0] toff;

  swreg_regs #(.PER_W(PER_W), .TOF_W(TOF_W), .CAL_CYC(CAL_CYC), .PER_RST(PER_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .width_rd(w_use), .rdata(reg_rdata), .conv_off(conv_off), .period(period),
    .toff(toff), .cal_busy(cal_busy)
  );

  always_comb begin
    run     = !conv_off && !cal_busy;
    off_len = PER_W'(toff) + PER_W'(TOF_ADD);
    min_per = off_len + 1'b1;
    p_eff   = (period < min_per) ? min_per : period;
    w_max   = p_eff - off_len;
  end

  swreg_loop #(.PER_W(PER_W)) u_loop (
    .clk(clk), .rst_n(rst_n), .run(run), .bnd(bnd), .fb_below(fb_below),
    .w_max(w_max), .w_use(w_use)
  );

  swreg_pwm #(.PER_W(PER_W)) u_pwm (
    .clk(clk), .rst_n(rst_n), .run(run), .p_eff(p_eff), .w_use(w_use),
    .ovl_in(ovl_in), .bnd(bnd), .blank_q(blank_q), .gate_p(gate_p)
  );

  assign gate_n = !gate_p;
endmodule

// File: rtl/swreg_chk.sv
module swreg_chk #(
  parameter int PER_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             cal_busy,
  input logic             bnd,
  input logic             blank_q,
  input logic             ovl_in,
  input logic             gate_p,
  input logic             gate_n,
  input logic [PER_W-1:0] w_use,
  input logic [PER_W-1:0] w_max
);
  a_r2_complement: assert property (@(posedge clk) disable iff (!rst_n) gate_n == !gate_p);
  a_r1_off_quiet:  assert property (@(posedge clk) disable iff (!rst_n) !run |-> !gate_p);
  a_r10_cal_quiet: assert property (@(posedge clk) disable iff (!rst_n) cal_busy |-> !gate_p);
  a_r6_ovl_kill:   assert property (@(posedge clk) disable iff (!rst_n) ovl_in |-> !gate_p);
  a_r4_width_bound: assert property (@(posedge clk) disable iff (!rst_n) w_use <= w_max);
  a_r7_blank_hold: assert property (@(posedge clk) disable iff (!rst_n)
                                    (blank_q && !bnd) |=> !gate_p);
endmodule

bind swreg_pwm_ctrl swreg_chk #(.PER_W(PER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .cal_busy(cal_busy), .bnd(bnd),
  .blank_q(blank_q), .ovl_in(ovl_in), .gate_p(gate_p), .gate_n(gate_n),
  .w_use(w_use), .w_max(w_max)
);

// File: tb/sim_swreg_pwm_ctrl.sv
module sim_swreg_pwm_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       fb_below = 1'b1;
  logic       ovl_in = 1'b0;
  logic       gate_p, gate_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  swreg_pwm_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fb_below(fb_below),
    .ovl_in(ovl_in), .gate_p(gate_p), .gate_n(gate_n)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output int v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic count_high(input int n, output int hi, output int bad_cmp);
    hi = 0; bad_cmp = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gate_p) hi++;
      if (gate_n == gate_p) bad_cmp++;
    end
  endtask

  task automatic wait_rise();
    while (gate_p) @(negedge clk);
    while (!gate_p) @(negedge clk);
  endtask

  task automatic t_reset();
    int v;
    check("R2 reset gate_n", gate_n, 1);
    check("R1 reset gate_p", gate_p, 0);
    rd_reg(2'd0, v); check("R1 reset off bit", v, 1);
    rd_reg(2'd1, v); check("R3 reset period", v, 40);
    rd_reg(2'd3, v); check("R5 reset width", v, 0);
  endtask

  task automatic t_ramp_up();
    int v, hi, bc;
    wr_reg(2'd1, 8'd20);
    wr_reg(2'd2, 8'd3);
    fb_below = 1'b1;
    wr_reg(2'd0, 8'd0);
    repeat (40 * 20) @(negedge clk);
    rd_reg(2'd3, v); check("R5 R4 width saturates at P-(T+4)", v, 13);
    count_high(20, hi, bc);
    check("R3 high clocks per period", hi, 13);
    check("R2 complement while switching", bc, 0);
    wr_reg(2'd3, 8'd2);
    rd_reg(2'd3, v); check("R9 width write ignored", v, 13);
  endtask

  task automatic t_ramp_down();
    int v, hi, bc;
    fb_below = 1'b0;
    repeat (40 * 20) @(negedge clk);
    rd_reg(2'd3, v); check("R5 width saturates at 0", v, 0);
    count_high(20, hi, bc);
    check("R5 no pulse at zero width", hi, 0);
  endtask

  task automatic t_period_clamp();
    int v, hi, bc;
    wr_reg(2'd1, 8'd4);
    fb_below = 1'b1;
    repeat (20 * 8) @(negedge clk);
    rd_reg(2'd3, v); check("R8 width max with clamped period", v, 1);
    count_high(16, hi, bc);
    check("R8 one pulse clock per 8-clock period", hi, 2);
    wr_reg(2'd1, 8'd20);
    repeat (40 * 20) @(negedge clk);
  endtask

  task automatic t_overload();
    int v, hi, bc;
    wait_rise();
    ovl_in = 1'b1;
    #1 check("R6 immediate off on overload", gate_p, 0);
    @(negedge clk);
    @(negedge clk);
    ovl_in = 1'b0;
    hi = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (gate_p) hi++;
    end
    check("R7 blank holds after overload drops", hi, 0);
    rd_reg(2'd3, v); check("R7 width kept through overload", v, 13);
    while (!gate_p) @(negedge clk);
    count_high(19, hi, bc);
    check("R7 full pulse next period", hi + 1, 13);
  endtask

  task automatic t_ovl_at_boundary();
    int hi;
    wait_rise();
    while (gate_p) @(negedge clk);
    repeat (6) @(negedge clk);
    ovl_in = 1'b1;
    @(negedge clk);
    ovl_in = 1'b0;
    #1 check("R7 boundary clears blank", gate_p, 1);
    hi = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (gate_p) hi++;
    end
    check("R7 next period unblanked", hi, 5);
  endtask

  task automatic t_calibrate();
    int v, hi, bc;
    wr_reg(2'd2, 8'h83);
    rd_reg(2'd2, v); check("R10 busy bit reads 1", v, 8'h83);
    count_high(60, hi, bc);
    check("R10 no switching in calibration", hi, 0);
    repeat (10) @(negedge clk);
    rd_reg(2'd2, v); check("R10 busy self-clears, T kept", v, 8'h03);
    count_high(40, hi, bc);
    check("R10 switching resumes", hi > 0, 1);
  endtask

  task automatic t_disable();
    int v, hi, bc;
    wr_reg(2'd0, 8'd1);
    rd_reg(2'd0, v); check("R1 off bit readback", v, 1);
    count_high(40, hi, bc);
    check("R1 gate_p held low when off", hi, 0);
    check("R2 gate_n high when off", bc, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_ramp_up();
    t_ramp_down();
    t_period_clamp();
    t_overload();
    t_ovl_at_boundary();
    t_calibrate();
    t_disable();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule